// File: doc/BRIEF.md
# Interrupt Entry Sequencer

This block sits beside the instruction sequencer of an 8-bit CPU. At every instruction boundary, which the core marks with an opcode-fetch indicator, it looks at the pending requests. Each cycle it takes the core's interrupt-disable flag and a free-running cycle count. Requests come from a reset line, a non-maskable line and two maskable lines, one from a video source and one from a timer source. When one of them wins, the block takes over the bus for a fixed run of cycles. An interrupt run pushes the return state onto the stack page and then reads a two-byte vector. A reset run only reads the vector.

Each cycle the block asks for at most one bus access, with an address and a direction. Its state code uses a reserved range so the rest of the core can tell an entry run from normal opcodes. A read waits while the bus is not available, and a write goes ahead regardless. The block keeps its own stack pointer, which reset sets to the top of the stack page. Every push moves that pointer down by one.

Top module: `intEntrySequencer`

## Requirements
- R1: A run starts only after a clock edge at which the block was idle and both fetchCycle and busAvail were high. startPulse and the first state code appear after that edge, and requests stay pending at all other times.
- R2: When several requests qualify at the same boundary, reset wins, then the non-maskable request, then a maskable one.
- R3: cycleCount advances by one per clock. A non-maskable or maskable request is taken only when cycleCount minus the count latched at the edge that first saw its line rise is at least 2. A line that rises with fetchCycle held high is therefore taken at the third edge.
- R4: A rising edge on nmiReq makes the non-maskable request pending, and acceptance clears it. Keeping nmiReq high does not make it pending again. Only a fall and a new rise does.
- R5: Either maskable line acts as a level request and is taken only while iFlag is low.
- R6: vectorAddr is 16'hFFFC after reset acceptance, 16'hFFFA after non-maskable acceptance and 16'hFFFE after maskable acceptance. The vector's low byte is read from vectorAddr and its high byte from vectorAddr+1.
- R7: seqState is 16'h0000 when idle. Otherwise it is a base code plus the step number in the low byte: non-maskable base 16'h0010 (steps 0-6), maskable base 16'h0018 (steps 0-6), reset base 16'h0020 (steps 0-1).
- R8: In an interrupt run, steps 0-1 read the stack address, steps 2-4 write the stack address, and steps 5-6 read the vector. The stack address is 16'h0100 plus the stack pointer, and each write lowers the stack pointer by one.
- R9: busReq marks exactly one access per active cycle. A read step with busAvail low makes no request and does not advance. A write step always requests and advances.
- R10: Reset acceptance sets the stack pointer to 8'hFF and clears the pending reset and non-maskable requests. It then runs two vector reads.
- R11: startPulse is high for exactly the first cycle of each run.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low block reset |
| resetReq | input | 1 | CPU reset request (level, latched) |
| nmiReq | input | 1 | Non-maskable request line |
| irqVideo | input | 1 | Maskable request from the video source |
| irqTimer | input | 1 | Maskable request from the timer source |
| iFlag | input | 1 | Interrupt-disable flag of the core |
| fetchCycle | input | 1 | High when the core is at its opcode-fetch step |
| busAvail | input | 1 | Bus available; low stalls read steps |
| cycleCount | input | CW | Free-running cycle count |
| startPulse | output | 1 | First cycle of an entry run |
| seqState | output | 16 | Entry state code, zero when idle |
| vectorAddr | output | 16 | Address of the selected vector's low byte |
| busReq | output | 1 | Bus access this cycle |
| busWrite | output | 1 | The access is a stack write |
| busAddr | output | 16 | Address of the access |

## Verification
The assertions rely on cycleCount rising by one per clock and on busAvail being a clean level sampled at the edge. They also rely on fetchCycle being meaningful only when the core is at a boundary. The bench drives cycleCount from its own counter on the falling edge and changes every request line, flag and bus-available level only on falling edges. The directed stimulus holds lines for whole cycles so that edge timing and hold-off can be counted exactly. The random stimulus toggles lines freely, but always between rising edges.

// File: rtl/intEntryPkg.sv
package intEntryPkg;
  typedef enum logic [1:0] {
    SRC_NONE  = 2'd0,
    SRC_RESET = 2'd1,
    SRC_NMI   = 2'd2,
    SRC_IRQ   = 2'd3
  } srcKind_t;

  typedef enum logic [1:0] {
    ADR_STACK = 2'd0,
    ADR_VECLO = 2'd1,
    ADR_VECHI = 2'd2
  } adrSel_t;

  // strobes from control to datapath
  typedef struct packed {
    logic     accept;
    srcKind_t kind;
    logic     pushDone;
  } seqStrobes_t;

  localparam logic [7:0]  CODE_NMI   = 8'h10;
  localparam logic [7:0]  CODE_IRQ   = 8'h18;
  localparam logic [7:0]  CODE_RESET = 8'h20;
  localparam logic [2:0]  LAST_INT   = 3'd6;
  localparam logic [2:0]  LAST_RESET = 3'd1;
  localparam logic [2:0]  FIRST_PUSH = 3'd2;
  localparam logic [2:0]  LAST_PUSH  = 3'd4;
  localparam logic [2:0]  VEC_STEP   = 3'd5;
  localparam logic [15:0] VEC_RESET  = 16'hFFFC;
  localparam logic [15:0] VEC_NMI    = 16'hFFFA;
  localparam logic [15:0] VEC_IRQ    = 16'hFFFE;
  localparam logic [7:0]  STACK_PAGE = 8'h01;
  localparam logic [7:0]  SP_TOP     = 8'hFF;
endpackage

// File: rtl/intEntryDatapath.sv
module intEntryDatapath
  import intEntryPkg::*;
#(
  parameter int CW      = 16,
  parameter int MIN_AGE = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          resetReq,
  input  logic          nmiReq,
  input  logic          irqVideo,
  input  logic          irqTimer,
  input  logic [CW-1:0] cycleCount,
  input  seqStrobes_t   strobes,
  output logic          resetPend,
  output logic          nmiReady,
  output logic          irqReady,
  output logic [15:0]   vectorAddr,
  output logic [15:0]   stackAddr
);
  localparam logic [CW-1:0] AGE = CW'(MIN_AGE);

  logic          nmiPrev, irqPrev, nmiPend;
  logic [CW-1:0] nmiStamp, irqStamp, nmiAge, irqAge;
  logic [7:0]    sp;
  logic          irqAny;

  assign irqAny    = irqVideo | irqTimer;
  assign nmiAge    = cycleCount - nmiStamp;
  assign irqAge    = cycleCount - irqStamp;
  assign nmiReady  = nmiPend && (nmiAge >= AGE);
  // irqPrev guarantees the stamp belongs to the current assertion
  assign irqReady  = irqAny && irqPrev && (irqAge >= AGE);
  assign stackAddr = {STACK_PAGE, sp};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      nmiPrev    <= 1'b0;
      irqPrev    <= 1'b0;
      nmiPend    <= 1'b0;
      resetPend  <= 1'b0;
      nmiStamp   <= '0;
      irqStamp   <= '0;
      sp         <= SP_TOP;
      vectorAddr <= VEC_RESET;
    end else begin
      nmiPrev <= nmiReq;
      irqPrev <= irqAny;
      if (irqAny && !irqPrev) irqStamp <= cycleCount;
      if (strobes.accept) begin
        unique case (strobes.kind)
          SRC_RESET: begin
            vectorAddr <= VEC_RESET;
            sp         <= SP_TOP;
            nmiPend    <= 1'b0;
            resetPend  <= 1'b0;
          end
          SRC_NMI: begin
            vectorAddr <= VEC_NMI;
            nmiPend    <= 1'b0;
          end
          SRC_IRQ:  vectorAddr <= VEC_IRQ;
          default:  ;
        endcase
      end else if (strobes.pushDone) begin
        sp <= sp - 8'd1;
      end
      // a fresh edge or a held reset line wins over the clear above
      if (nmiReq && !nmiPrev) begin
        nmiPend  <= 1'b1;
        nmiStamp <= cycleCount;
      end
      if (resetReq) resetPend <= 1'b1;
    end
  end
endmodule

// File: rtl/intEntryControl.sv
module intEntryControl
  import intEntryPkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        fetchCycle,
  input  logic        busAvail,
  input  logic        iFlag,
  input  logic        resetPend,
  input  logic        nmiReady,
  input  logic        irqReady,
  output seqStrobes_t strobes,
  output logic        startPulse,
  output logic [15:0] seqState,
  output logic        busReq,
  output logic        busWrite,
  output adrSel_t     adrSel
);
  logic     active;
  srcKind_t kind, pick;
  logic [2:0] step;
  logic     accept, isPush, go, last;
  logic [7:0] base;

  always_comb begin
    if (resetPend)                pick = SRC_RESET;
    else if (nmiReady)            pick = SRC_NMI;
    else if (irqReady && !iFlag)  pick = SRC_IRQ;
    else                          pick = SRC_NONE;
  end

  assign accept = !active && fetchCycle && busAvail && (pick != SRC_NONE);
  assign isPush = active && (kind != SRC_RESET) &&
                  (step >= FIRST_PUSH) && (step <= LAST_PUSH);
  assign go     = active && (isPush || busAvail);
  assign last   = (kind == SRC_RESET) ? (step == LAST_RESET) : (step == LAST_INT);

  assign strobes  = '{accept: accept, kind: pick, pushDone: go && isPush};
  assign busReq   = go;
  assign busWrite = isPush;

  always_comb begin
    unique case (kind)
      SRC_NMI:   base = CODE_NMI;
      SRC_IRQ:   base = CODE_IRQ;
      SRC_RESET: base = CODE_RESET;
      default:   base = 8'h00;
    endcase
    seqState = active ? {8'h00, base + {5'd0, step}} : 16'h0000;
  end

  always_comb begin
    if (kind == SRC_RESET)  adrSel = (step == 3'd0) ? ADR_VECLO : ADR_VECHI;
    else if (step == VEC_STEP) adrSel = ADR_VECLO;
    else if (step == LAST_INT) adrSel = ADR_VECHI;
    else                    adrSel = ADR_STACK;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active     <= 1'b0;
      kind       <= SRC_NONE;
      step       <= 3'd0;
      startPulse <= 1'b0;
    end else begin
      startPulse <= accept;
      if (accept) begin
        active <= 1'b1;
        kind   <= pick;
        step   <= 3'd0;
      end else if (go) begin
        if (last) begin
          active <= 1'b0;
          step   <= 3'd0;
        end else begin
          step <= step + 3'd1;
        end
      end
    end
  end
endmodule

// File: rtl/intEntrySequencer.sv
module intEntrySequencer
  import intEntryPkg::*;
#(
  parameter int CW      = 16,
  parameter int MIN_AGE = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          resetReq,
  input  logic          nmiReq,
  input  logic          irqVideo,
  input  logic          irqTimer,
  input  logic          iFlag,
  input  logic          fetchCycle,
  input  logic          busAvail,
  input  logic [CW-1:0] cycleCount,
  output logic          startPulse,
  output logic [15:0]   seqState,
  output logic [15:0]   vectorAddr,
  output logic          busReq,
  output logic          busWrite,
  output logic [15:0]   busAddr
);
  seqStrobes_t strobes;
  adrSel_t     adrSel;
  logic        resetPend, nmiReady, irqReady;
  logic [15:0] stackAddr;

  intEntryDatapath #(.CW(CW), .MIN_AGE(MIN_AGE)) u_dp (
    .clk(clk), .rst_n(rst_n), .resetReq(resetReq), .nmiReq(nmiReq),
    .irqVideo(irqVideo), .irqTimer(irqTimer), .cycleCount(cycleCount),
    .strobes(strobes), .resetPend(resetPend), .nmiReady(nmiReady),
    .irqReady(irqReady), .vectorAddr(vectorAddr), .stackAddr(stackAddr)
  );

  intEntryControl u_ctl (
    .clk(clk), .rst_n(rst_n), .fetchCycle(fetchCycle), .busAvail(busAvail),
    .iFlag(iFlag), .resetPend(resetPend), .nmiReady(nmiReady),
    .irqReady(irqReady), .strobes(strobes), .startPulse(startPulse),
    .seqState(seqState), .busReq(busReq), .busWrite(busWrite), .adrSel(adrSel)
  );

  always_comb begin
    unique case (adrSel)
      ADR_VECLO: busAddr = vectorAddr;
      ADR_VECHI: busAddr = vectorAddr + 16'd1;
      default:   busAddr = stackAddr;
    endcase
  end
endmodule

// File: rtl/intEntryChecker.sv
module intEntryChecker (
  input logic        clk,
  input logic        rst_n,
  input logic        fetchCycle,
  input logic        busAvail,
  input logic        iFlag,
  input logic        resetPend,
  input logic        startPulse,
  input logic [15:0] seqState,
  input logic [15:0] vectorAddr,
  input logic        busReq,
  input logic        busWrite,
  input logic [15:0] busAddr
);
  assert_boundary_R1: assert property (@(posedge clk) disable iff (!rst_n)
    startPulse |-> $past(fetchCycle && busAvail));

  assert_priority_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (startPulse && seqState != 16'h0020) |-> !$past(resetPend));

  assert_mask_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (startPulse && seqState == 16'h0018) |-> !$past(iFlag));

  assert_vector_R6: assert property (@(posedge clk) disable iff (!rst_n)
    startPulse |-> ((seqState == 16'h0020 && vectorAddr == 16'hFFFC) ||
                    (seqState == 16'h0010 && vectorAddr == 16'hFFFA) ||
                    (seqState == 16'h0018 && vectorAddr == 16'hFFFE)));

  assert_code_range_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (seqState != 16'h0000) |-> (seqState >= 16'h0010 && seqState <= 16'h0027));

  assert_stack_write_R8: assert property (@(posedge clk) disable iff (!rst_n)
    busWrite |-> (busReq && busAddr[15:8] == 8'h01));

  assert_read_stall_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (seqState != 16'h0000 && !busWrite && !busAvail) |=> $stable(seqState));

  assert_no_req_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (seqState == 16'h0000) |-> !busReq);

  assert_pulse_once_R11: assert property (@(posedge clk) disable iff (!rst_n)
    startPulse |=> !startPulse);
endmodule

bind intEntrySequencer intEntryChecker u_chk (
  .clk(clk), .rst_n(rst_n), .fetchCycle(fetchCycle), .busAvail(busAvail),
  .iFlag(iFlag), .resetPend(resetPend), .startPulse(startPulse),
  .seqState(seqState), .vectorAddr(vectorAddr), .busReq(busReq),
  .busWrite(busWrite), .busAddr(busAddr)
);

// File: tb/intEntrySequencer_bench.sv
module intEntrySequencer_bench;
  localparam int CLK_NS = 20;

  logic clk = 1'b0, rst_n = 1'b0;
  logic resetReq = 0, nmiReq = 0, irqVideo = 0, irqTimer = 0;
  logic iFlag = 1, fetchCycle = 0, busAvail = 1;
  logic [15:0] cycleCount = 16'd0;
  logic startPulse, busReq, busWrite;
  logic [15:0] seqState, vectorAddr, busAddr;

  int checks = 0, fails = 0;
  bit finished = 0;

  always #(CLK_NS/2) clk = ~clk;
  always @(negedge clk) cycleCount <= cycleCount + 16'd1;

  intEntrySequencer u_intEntrySequencer (
    .clk(clk), .rst_n(rst_n), .resetReq(resetReq), .nmiReq(nmiReq),
    .irqVideo(irqVideo), .irqTimer(irqTimer), .iFlag(iFlag),
    .fetchCycle(fetchCycle), .busAvail(busAvail), .cycleCount(cycleCount),
    .startPulse(startPulse), .seqState(seqState), .vectorAddr(vectorAddr),
    .busReq(busReq), .busWrite(busWrite), .busAddr(busAddr)
  );

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // ---------------- behavioural reference ----------------
  int mActive, mKind, mStep, mSp, mNmiPend, mNmiStamp, mIrqStamp;
  int mPrevNmi, mPrevIrq, mResetPend, mVec, mStart;

  function automatic int mPush();
    return (mActive != 0 && mKind != 1 && mStep >= 2 && mStep <= 4) ? 1 : 0;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      mActive = 0; mKind = 0; mStep = 0; mSp = 'hFF; mNmiPend = 0;
      mNmiStamp = 0; mIrqStamp = 0; mPrevNmi = 0; mPrevIrq = 0;
      mResetPend = 0; mVec = 'hFFFC; mStart = 0;
    end else begin
      int irqAny, pick, acc, go, last, cc;
      cc = cycleCount;
      irqAny = (irqVideo | irqTimer) ? 1 : 0;
      pick = 0;
      if (mResetPend != 0) pick = 1;
      else if (mNmiPend != 0 && ((cc - mNmiStamp) & 'hFFFF) >= 2) pick = 2;
      else if (irqAny != 0 && mPrevIrq != 0 && ((cc - mIrqStamp) & 'hFFFF) >= 2 && !iFlag) pick = 3;
      acc  = (mActive == 0 && fetchCycle && busAvail && pick != 0) ? 1 : 0;
      go   = (mActive != 0 && (mPush() != 0 || busAvail)) ? 1 : 0;
      last = (mKind == 1) ? (mStep == 1) : (mStep == 6);
      mStart = acc;
      if (acc != 0) begin
        if (pick == 1) begin mVec = 'hFFFC; mSp = 'hFF; mNmiPend = 0; mResetPend = 0; end
        else if (pick == 2) begin mVec = 'hFFFA; mNmiPend = 0; end
        else mVec = 'hFFFE;
        mActive = 1; mKind = pick; mStep = 0;
      end else if (go != 0) begin
        if (mPush() != 0) mSp = (mSp - 1) & 'hFF;
        if (last != 0) begin mActive = 0; mStep = 0; end
        else mStep = mStep + 1;
      end
      if (irqAny != 0 && mPrevIrq == 0) mIrqStamp = cc;
      if (nmiReq && mPrevNmi == 0) begin mNmiPend = 1; mNmiStamp = cc; end
      if (resetReq) mResetPend = 1;
      mPrevNmi = nmiReq ? 1 : 0;
      mPrevIrq = irqAny;
    end
  end

  // compare every cycle, between rising and falling edge
  always @(posedge clk) begin
    #5;
    if (rst_n && !finished) begin
      int eState, eReq, eAddr, base;
      base  = (mKind == 1) ? 'h20 : (mKind == 2) ? 'h10 : 'h18;
      eState = (mActive != 0) ? base + mStep : 0;
      eReq  = (mActive != 0 && (mPush() != 0 || busAvail)) ? 1 : 0;
      if (mKind == 1) eAddr = (mStep == 0) ? mVec : mVec + 1;
      else if (mStep == 5) eAddr = mVec;
      else if (mStep == 6) eAddr = mVec + 1;
      else eAddr = 'h100 + mSp;
      check("R7 seqState", seqState, eState);
      check("R11 startPulse", startPulse, mStart);
      check("R9 busReq", busReq, eReq);
      check("R8 busWrite", busWrite, mPush());
      check("R6 vectorAddr", vectorAddr, mVec);
      if (eReq != 0) check("R8 busAddr", busAddr, eAddr);
    end
  end

  // ---------------- stimulus ----------------
  task automatic waitN(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic fetchOnce();
    @(negedge clk) fetchCycle = 1;
    @(negedge clk) fetchCycle = 0;
  endtask

  task automatic finish();
    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    #(CLK_NS * 200000);
    fails++;
    checks++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    finish();
  end

  initial begin
    waitN(3);
    rst_n = 1;
    waitN(1);
    check("R7 reset state", seqState, 0);
    check("R9 reset no request", busReq, 0);
    check("R6 reset vector", vectorAddr, 'hFFFC);
    check("R11 reset pulse", startPulse, 0);

    // reset request run
    @(negedge clk) resetReq = 1;
    @(negedge clk) begin resetReq = 0; fetchCycle = 1; end
    @(negedge clk) fetchCycle = 0;
    check("R10 reset run start", seqState, 'h20);
    check("R10 reset vec lo", busAddr, 'hFFFC);
    waitN(1);
    check("R10 reset vec hi", busAddr, 'hFFFD);
    waitN(2);

    // non-maskable held off outside boundary
    nmiReq = 1;
    waitN(4);
    check("R1 no boundary no start", seqState, 0);
    fetchOnce();
    check("R4 nmi start", seqState, 'h10);
    check("R6 nmi vector", vectorAddr, 'hFFFA);
    check("R11 nmi pulse", startPulse, 1);
    waitN(2);
    check("R8 first push addr", busAddr, 'h01FF);
    check("R8 first push write", busWrite, 1);
    waitN(6);
    fetchOnce();
    check("R4 held line no retrigger", seqState, 0);

    // two-cycle qualification
    nmiReq = 0;
    waitN(2);
    nmiReq = 1; fetchCycle = 1;
    waitN(1);
    check("R3 edge cycle not taken", seqState, 0);
    waitN(1);
    check("R3 age one not taken", seqState, 0);
    waitN(1);
    check("R3 age two taken", seqState, 'h10);
    fetchCycle = 0;
    waitN(8);

    // maskable masked then unmasked
    iFlag = 1; irqTimer = 1; fetchCycle = 1;
    waitN(5);
    check("R5 masked", seqState, 0);
    iFlag = 0;
    waitN(1);
    fetchCycle = 0;
    check("R5 unmasked start", seqState, 'h18);
    check("R6 irq vector", vectorAddr, 'hFFFE);
    waitN(8);
    iFlag = 1; irqTimer = 0;

    // priority: reset over nmi over irq
    irqVideo = 1;
    nmiReq = 0; waitN(1);
    nmiReq = 1; resetReq = 1; waitN(1);
    resetReq = 0; waitN(3);
    iFlag = 0;
    fetchOnce();
    check("R2 reset wins", seqState, 'h20);
    waitN(3);
    fetchOnce();
    check("R10 reset cleared nmi", seqState, 'h18);
    waitN(8);
    nmiReq = 0; waitN(1);
    nmiReq = 1; waitN(3);
    fetchOnce();
    check("R2 nmi over irq", seqState, 'h10);
    waitN(8);
    iFlag = 1; irqVideo = 0;

    // bus stall behaviour
    nmiReq = 0; waitN(1);
    nmiReq = 1; waitN(3);
    fetchOnce();
    busAvail = 0;
    waitN(1);
    check("R9 read stalls", seqState, 'h10);
    check("R9 no request on stall", busReq, 0);
    busAvail = 1;
    waitN(2);
    check("R8 push step", seqState, 'h12);
    busAvail = 0;
    waitN(1);
    check("R9 write proceeds", seqState, 'h13);
    busAvail = 1;
    waitN(8);

    // random phase, compared every cycle against the reference
    for (int i = 0; i < 600; i++) begin
      @(negedge clk);
      if ($urandom_range(7) == 0) nmiReq = ~nmiReq;
      if ($urandom_range(9) == 0) irqVideo = ~irqVideo;
      if ($urandom_range(11) == 0) irqTimer = ~irqTimer;
      if ($urandom_range(5) == 0) iFlag = ~iFlag;
      fetchCycle = ($urandom_range(2) == 0);
      busAvail   = ($urandom_range(3) != 0);
      resetReq   = ($urandom_range(59) == 0);
    end
    @(negedge clk) begin resetReq = 0; fetchCycle = 0; busAvail = 1; end
    waitN(12);
    finish();
  end
endmodule